// File: doc/BRIEF.md
# Machine Check Bank Logger

The block keeps the error-reporting banks of one processor core. Each bank holds four 64-bit registers: a control mask, a status word, an error address and a miscellaneous word. Three global registers sit beside them: a capability word that declares how many banks exist and whether a global control mask is present, that global control mask, and a global status word whose MCIP bit marks a machine-check exception in progress.

An injection port presents one error report per cycle. The report carries a bank number, a status word, a global status word, an address, a misc word and an unconditional flag. The block checks the request and applies the corrected or uncorrected update rules, including overflow marking. It then returns one result code one cycle later. For an uncorrected error that is logged, it also pulses an interrupt. When the core cannot take the error, it pulses a reset request instead. Software reads and writes every register through a simple word-addressed port.

Top module: `mc_bank_logger`

## Requirements
- R1: A request is rejected (code 3) when its bank number is not below capability bits 7:0, or is not below the NBANK parameter. The capability resets to NBANK with bit 8 set.
- R2: A request whose status bit 63 (valid) is clear is rejected (code 3). No register changes.
- R3: A report whose status bit 55 (action required) is clear is ignored (code 1) while global status bit 2 (MCIP) is set, unless inj_uncond is high.
- R4: An uncorrected report (status bit 61) is ignored when capability bit 8 is set and the global control is not all ones. With capability bit 8 clear, the global control has no effect.
- R5: An uncorrected report is ignored when the control mask of the target bank is not all ones.
- R6: An uncorrected report that passes R4 and R5 gives code 2 and a one-cycle reset_req pulse when mce_enable is low or MCIP is set. The bank is left untouched.
- R7: Otherwise an uncorrected report is logged with code 0. Bit 62 (overflow) is added to the new status if the bank already held a valid status. The bank address, misc and status are written, the global status is loaded from inj_gstatus, and mce_irq pulses for one cycle.
- R8: A corrected report overwrites address, misc and status when the old status is not valid or not uncorrected. Overflow is set when a valid entry was replaced. The code is 0.
- R9: A corrected report that meets a valid uncorrected entry only sets overflow in that status. Address and misc are kept. The code is 0.
- R10: Register map: address bit 4 set selects a global register (field 0 capability, 1 global control, 2 global status). Bit 4 clear selects bank addr[3:2] with field addr[1:0] (0 control, 1 status, 2 address, 3 misc). Reads are combinational. Writes take effect at the clock edge. Everything except the capability resets to zero.
- R11: res_valid, res_code, mce_irq and reset_req are registered and appear in the cycle after inj_valid. The codes are 0 logged, 1 ignored, 2 reset, 3 rejected.
- R12: When a software write and an injection update the same register in one cycle, the injection value is kept. A write to any other register still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mce_enable | input | 1 | Core accepts machine-check exceptions |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data |
| inj_valid | input | 1 | Injection request |
| inj_bank | input | 8 | Target bank number |
| inj_status | input | 64 | Reported bank status |
| inj_gstatus | input | 64 | Global status loaded on an uncorrected log |
| inj_addr | input | 64 | Reported error address |
| inj_misc | input | 64 | Reported misc word |
| inj_uncond | input | 1 | Bypass the MCIP ignore rule |
| res_valid | output | 1 | Result present |
| res_code | output | 2 | Outcome code |
| mce_irq | output | 1 | Machine-check interrupt pulse |
| reset_req | output | 1 | Reset request pulse |

## Verification
A software register write and an injection can fall in the same clock edge and aim at the same bank status. The bench provokes this by driving reg_we and inj_valid together, once on the same register and once on two different registers. A read-back in the next cycle judges the result: the injected value must stand in the shared register, and the unrelated write must also have landed. A behavioural model in the bench applies the write first and the injection second, and is compared on every clock.

// File: rtl/mc_bank_logger.sv
module mc_bank_logger #(
  parameter int NBANK = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mce_enable,
  input  logic                       reg_we,
  input  logic [$clog2(NBANK)+2:0]   reg_addr,
  input  logic [63:0]                reg_wdata,
  output logic [63:0]                reg_rdata,
  input  logic                       inj_valid,
  input  logic [7:0]                 inj_bank,
  input  logic [63:0]                inj_status,
  input  logic [63:0]                inj_gstatus,
  input  logic [63:0]                inj_addr,
  input  logic [63:0]                inj_misc,
  input  logic                       inj_uncond,
  output logic                       res_valid,
  output logic [1:0]                 res_code,
  output logic                       mce_irq,
  output logic                       reset_req
);
  localparam int BW = $clog2(NBANK);
  localparam int AW = BW + 3;
  localparam logic [63:0] OVER_M = 64'h1 << 62;
  localparam logic [1:0] C_INJ = 2'd0, C_IGN = 2'd1, C_RST = 2'd2, C_REJ = 2'd3;

  logic [63:0] b_ctl [NBANK];
  logic [63:0] b_sts [NBANK];
  logic [63:0] b_adr [NBANK];
  logic [63:0] b_msc [NBANK];
  logic [63:0] cap_q, gctl_q, gst_q;

  wire          glb   = reg_addr[AW-1];
  wire [BW-1:0] rbank = reg_addr[AW-2:2];
  wire [1:0]    rfld  = reg_addr[1:0];

  always_comb begin
    reg_rdata = '0;
    if (glb) begin
      case (rfld)
        2'd0: reg_rdata = cap_q;
        2'd1: reg_rdata = gctl_q;
        2'd2: reg_rdata = gst_q;
        default: reg_rdata = '0;
      endcase
    end else begin
      case (rfld)
        2'd0: reg_rdata = b_ctl[rbank];
        2'd1: reg_rdata = b_sts[rbank];
        2'd2: reg_rdata = b_adr[rbank];
        default: reg_rdata = b_msc[rbank];
      endcase
    end
  end

  wire [BW-1:0] ib      = inj_bank[BW-1:0];
  wire          bank_ok = (inj_bank < cap_q[7:0]) && (inj_bank < 8'(NBANK));
  wire [63:0]   old     = b_sts[ib];
  wire          mcip    = gst_q[2];
  wire          is_uc   = inj_status[61];
  wire          uc_off  = (cap_q[8] && gctl_q != '1) || (b_ctl[ib] != '1);

  logic [1:0] code;
  logic wr_full, wr_over, wr_gst;

  always_comb begin
    code = C_IGN; wr_full = 1'b0; wr_over = 1'b0; wr_gst = 1'b0;
    if (!bank_ok || !inj_status[63])                 code = C_REJ;
    else if (!inj_uncond && !inj_status[55] && mcip) code = C_IGN;
    else if (is_uc) begin
      if (uc_off)                        code = C_IGN;
      else if (!mce_enable || mcip)      code = C_RST;
      else begin code = C_INJ; wr_full = 1'b1; wr_gst = 1'b1; end
    end else begin
      code = C_INJ;
      if (!old[63] || !old[61]) wr_full = 1'b1;
      else                      wr_over = 1'b1;
    end
  end

  wire go_full = inj_valid && wr_full;
  wire go_over = inj_valid && wr_over;
  wire go_gst  = inj_valid && wr_gst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0; res_code <= C_INJ; mce_irq <= 1'b0; reset_req <= 1'b0;
      cap_q  <= 64'(NBANK) | (64'h1 << 8);
      gctl_q <= '0;
      gst_q  <= '0;
      for (int i = 0; i < NBANK; i++) begin
        b_ctl[i] <= '0; b_sts[i] <= '0; b_adr[i] <= '0; b_msc[i] <= '0;
      end
    end else begin
      res_valid <= inj_valid;
      res_code  <= inj_valid ? code : C_INJ;
      mce_irq   <= go_gst;
      reset_req <= inj_valid && code == C_RST;
      if (reg_we) begin
        if (glb) begin
          case (rfld)
            2'd0: cap_q  <= reg_wdata;
            2'd1: gctl_q <= reg_wdata;
            2'd2: gst_q  <= reg_wdata;
            default: ;
          endcase
        end else begin
          case (rfld)
            2'd0: b_ctl[rbank] <= reg_wdata;
            2'd1: b_sts[rbank] <= reg_wdata;
            2'd2: b_adr[rbank] <= reg_wdata;
            default: b_msc[rbank] <= reg_wdata;
          endcase
        end
      end
      if (go_full) begin
        b_adr[ib] <= inj_addr;
        b_msc[ib] <= inj_misc;
        b_sts[ib] <= inj_status | (old[63] ? OVER_M : 64'h0);
      end
      if (go_over) b_sts[ib] <= old | OVER_M;
      if (go_gst)  gst_q <= inj_gstatus;
    end
  end

  a_r7_irq_means_logged: assert property (@(posedge clk) disable iff (!rst_n)
    mce_irq |-> (res_valid && res_code == C_INJ));
  a_r6_reset_code: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (res_valid && res_code == C_RST));
  a_r7_gstat_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    mce_irq |-> gst_q == $past(inj_gstatus));
  a_r11_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(inj_valid));
  a_r11_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mce_irq && reset_req));
  a_r1_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == C_REJ) |-> (!mce_irq && !reset_req));
endmodule

// File: tb/mc_bank_logger_tb.sv
`timescale 1ns/1ps
module mc_bank_logger_tb_top;
  localparam int NB = 4;
  localparam logic [63:0] VAL = 64'h1 << 63, OVR = 64'h1 << 62, UC = 64'h1 << 61, AR = 64'h1 << 55;
  localparam logic [63:0] ONES = '1;

  logic clk = 0, rst_n = 0, mce_enable = 0, reg_we = 0, inj_valid = 0, inj_uncond = 0;
  logic [4:0] reg_addr = 0;
  logic [63:0] reg_wdata = 0, reg_rdata, inj_status = 0, inj_gstatus = 0, inj_addr = 0, inj_misc = 0;
  logic [7:0] inj_bank = 0;
  logic res_valid, mce_irq, reset_req;
  logic [1:0] res_code;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mc_bank_logger #(.NBANK(NB)) dut_i (.*);

  logic [63:0] m_ctl [NB], m_sts [NB], m_adr [NB], m_msc [NB];
  logic [63:0] m_cap, m_gctl, m_gst;
  logic e_rv, e_irq, e_rst;
  logic [1:0] e_code;

  function automatic logic [63:0] mread(input logic [4:0] a);
    int b = a[3:2];
    if (a[4]) return a[1:0] == 0 ? m_cap : a[1:0] == 1 ? m_gctl : a[1:0] == 2 ? m_gst : 64'h0;
    case (a[1:0])
      0: return m_ctl[b];
      1: return m_sts[b];
      2: return m_adr[b];
      default: return m_msc[b];
    endcase
  endfunction

  task automatic mreset();
    m_cap = 64'h104; m_gctl = 0; m_gst = 0;
    for (int i = 0; i < NB; i++) begin m_ctl[i] = 0; m_sts[i] = 0; m_adr[i] = 0; m_msc[i] = 0; end
  endtask

  task automatic mstep();
    int b = inj_bank;
    logic [63:0] o;
    logic full = 0, ovr = 0, gs = 0;
    e_rv = inj_valid; e_code = 0; e_irq = 0; e_rst = 0;
    if (inj_valid) begin
      o = (b < NB) ? m_sts[b] : 64'h0;
      if (b >= int'(m_cap[7:0]) || b >= NB || !inj_status[63]) e_code = 3;
      else if (!inj_uncond && !inj_status[55] && m_gst[2]) e_code = 1;
      else if (inj_status[61]) begin
        if ((m_cap[8] && m_gctl != ONES) || m_ctl[b] != ONES) e_code = 1;
        else if (!mce_enable || m_gst[2]) begin e_code = 2; e_rst = 1; end
        else begin full = 1; gs = 1; e_irq = 1; end
      end else if (o[63] && o[61]) ovr = 1;
      else full = 1;
    end
    if (reg_we) begin
      int rb = reg_addr[3:2];
      if (reg_addr[4]) begin
        if (reg_addr[1:0] == 0) m_cap = reg_wdata;
        else if (reg_addr[1:0] == 1) m_gctl = reg_wdata;
        else if (reg_addr[1:0] == 2) m_gst = reg_wdata;
      end else case (reg_addr[1:0])
        0: m_ctl[rb] = reg_wdata;
        1: m_sts[rb] = reg_wdata;
        2: m_adr[rb] = reg_wdata;
        default: m_msc[rb] = reg_wdata;
      endcase
    end
    if (full) begin
      m_adr[b] = inj_addr; m_msc[b] = inj_misc;
      m_sts[b] = inj_status | (o[63] ? OVR : 64'h0);
    end
    if (ovr) m_sts[b] = o | OVR;
    if (gs) m_gst = inj_gstatus;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    #1;
    chk({tag, " R10 rdata"}, reg_rdata, mread(reg_addr));
    mstep();
    @(posedge clk); #1;
    chk({tag, " R11 outputs"}, {60'h0, res_valid, res_code, mce_irq, reset_req} & 64'h1f,
        {59'h0, e_rv, e_code, e_irq, e_rst});
    @(negedge clk);
    reg_we = 0; inj_valid = 0; inj_uncond = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [63:0] d, input string tag);
    reg_addr = a; reg_wdata = d; reg_we = 1; tick(tag);
  endtask

  task automatic rd(input logic [4:0] a, input logic [63:0] exp, input string tag);
    reg_addr = a; #1; chk({tag, " readback"}, reg_rdata, exp); tick(tag);
  endtask

  task automatic inj(input int b, input logic [63:0] st, input logic [63:0] gs, input logic [63:0] ad,
                     input bit unc, input logic [1:0] exp, input string tag);
    inj_bank = 8'(b); inj_status = st; inj_gstatus = gs; inj_addr = ad; inj_misc = ~ad;
    inj_uncond = unc; inj_valid = 1;
    tick(tag);
    chk({tag, " code"}, {62'h0, res_code}, {62'h0, exp});
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mreset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(5'd16, 64'h104, "R1 R10 reset capability");
    rd(5'd1, 64'h0, "R10 reset status");
    wr(5'd17, ONES, "R10 gctl");
    for (int i = 0; i < NB; i++) wr(5'(i * 4), ONES, "R10 bank ctl");
    rd(5'd17, ONES, "R10 gctl back");
    inj(0, VAL | 64'h11, 0, 64'hA0, 0, 2'd0, "R8 corrected first");
    rd(5'd1, VAL | 64'h11, "R8 status");
    inj(0, VAL | 64'h22, 0, 64'hA1, 0, 2'd0, "R8 corrected replace");
    rd(5'd1, VAL | OVR | 64'h22, "R8 overflow");
    inj(5, VAL, 0, 0, 0, 2'd3, "R1 bank beyond");
    inj(0, 64'h33, 0, 0, 0, 2'd3, "R2 no valid");
    rd(5'd1, VAL | OVR | 64'h22, "R2 untouched");
    inj(1, VAL | UC | 64'h3, 0, 64'hB0, 0, 2'd2, "R6 mce disabled");
    rd(5'd5, 64'h0, "R6 bank untouched");
    mce_enable = 1;
    inj(1, VAL | UC | 64'h5, 64'h5, 64'hB1, 0, 2'd0, "R7 uc logged");
    rd(5'd18, 64'h5, "R7 gstatus");
    inj(2, VAL | 64'h6, 0, 64'hC0, 0, 2'd1, "R3 ignored under mcip");
    rd(5'd9, 64'h0, "R3 untouched");
    inj(2, VAL | 64'h6, 0, 64'hC0, 1, 2'd0, "R3 uncond");
    inj(3, VAL | UC | AR, 0, 64'hD0, 0, 2'd2, "R6 mcip set");
    wr(5'd18, 64'h0, "R10 clear gstatus");
    inj(1, VAL | UC | 64'h7, 64'h4, 64'hB2, 0, 2'd0, "R7 uc over");
    rd(5'd5, VAL | OVR | UC | 64'h7, "R7 over status");
    inj(1, VAL | AR | 64'h9, 64'h0, 64'hBEEF, 0, 2'd0, "R9 corrected on uc");
    rd(5'd6, 64'hB2, "R9 address kept");
    rd(5'd5, VAL | OVR | UC | 64'h7, "R9 status over only");
    wr(5'd18, 64'h0, "R10 clear gstatus");
    wr(5'd17, 64'h0, "R4 gctl off");
    inj(3, VAL | UC, 64'h0, 64'hE0, 0, 2'd1, "R4 suppressed");
    wr(5'd16, 64'h4, "R4 ctl-present clear");
    inj(3, VAL | UC, 64'h0, 64'hE1, 0, 2'd0, "R4 not suppressed");
    wr(5'd12, 64'hFF, "R5 bank ctl partial");
    inj(3, VAL | UC | 64'h1, 64'h0, 64'hE2, 0, 2'd1, "R5 suppressed");
    rd(5'd14, 64'hE1, "R5 address kept");
    wr(5'd16, 64'h2, "R1 cap two banks");
    inj(3, VAL, 0, 0, 0, 2'd3, "R1 bank above cap");
    inj(1, VAL, 0, 64'hF0, 0, 2'd0, "R1 bank below cap");
    reg_addr = 5'd1; reg_wdata = 64'h55; reg_we = 1;
    inj(0, VAL | 64'h77, 0, 64'h99, 0, 2'd0, "R12 same register");
    rd(5'd1, VAL | OVR | 64'h77, "R12 injection wins");
    reg_addr = 5'd10; reg_wdata = 64'h1234; reg_we = 1;
    inj(0, VAL | 64'h78, 0, 64'h9A, 0, 2'd0, "R12 other register");
    rd(5'd10, 64'h1234, "R12 write kept");
    rd(5'd2, 64'h9A, "R12 inject kept");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule